// File: doc/BRIEF.md
# 8-bit ALU with condition flags

This block is the arithmetic and logic unit of a small accumulator-based controller core. Each cycle it takes an operation code, two 8-bit operands and the current condition flags (overflow V, half-carry H, negative N, zero Z, carry C). It returns the 8-bit result, a full updated flag vector, a mask that says which flags the operation wrote, and a strobe that says whether the result should be written back. The carry or borrow input for the carry-using operations is the C bit of the incoming flag vector.

Each operation has its own flag rules. Half-carry is produced only by the two additions. Shifts and rotates derive V from the new C and N. Negate, complement and clear force particular flag values. Flags that an operation does not touch leave the block unchanged, so the caller can load the flag vector directly. The unary operations (shifts, increment, decrement, negate, complement, clear) act on operand A. The pass-through operation forwards operand B. Everything is computed in one combinational stage and registered once, so results appear one clock after the inputs.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a rising edge, `result_o`, `flags_o` and `flag_we_o` become 0 and `wb_o` becomes 0.
- R2: The outputs present the response to the inputs sampled at the previous rising edge: exactly one cycle of latency.
- R3: Add (op 0) and add-with-carry (op 1, carry-in = flags_i C) form r = a + b (+cin) as a 9-bit value. The result is r[7:0], C = r[8], H = bit 4 of (a^b^r), and V = bit 7 of (a^b^r^(r>>1)). All five flags are written.
- R4: Subtract (op 2) and subtract-with-borrow (op 3, borrow-in = flags_i C) form r = a - b (-cin) modulo 512. C = r[8] acts as a borrow, and V uses the same expression as R3. H is not written, so it keeps its input value.
- R5: Compare (op 4) sets flags as subtract does, and bit-test (op 8) sets flags as AND does. Neither asserts `wb_o`. Every other defined opcode 0 to 19 asserts `wb_o`.
- R6: AND (5), OR (6), XOR (7), bit-test (8) and pass-through of B (9) clear V, set N and Z from the result, and keep H and C.
- R7: The shifts act on A and put the bit shifted out into C. Arithmetic right (10) keeps bit 7, logical right (11) inserts 0, left (12) inserts 0, rotate left (13) inserts the old C at bit 0, and rotate right (14) inserts the old C at bit 7.
- R8: For opcodes 10 to 14, V equals the new C XOR the new N, and H is kept.
- R9: Increment (15) and decrement (16) of A set V only for results 0x80 and 0x7F respectively. They keep C and H.
- R10: Negate (17) gives (0 - A) mod 256, with V = (A == 0x80) and C = (A != 0), and keeps H.
- R11: Complement (18) gives ~A, sets C and clears V. Clear (19) gives 0, clears N and V, sets Z, and keeps H and C.
- R12: Flag vectors use the bit positions V=4, H=3, N=2, Z=1, C=0. `flag_we_o` marks the flags the operation wrote, and every flag not marked equals its `flags_i` value. Opcodes 20 to 31 write no flag, give result 0 and deassert `wb_o`.
- R13: Unless forced by R11, N is bit 7 of the result and Z is set exactly when the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code (0 to 19 defined) |
| a_i | input | 8 | Operand A (accumulator side, source of unary operations) |
| b_i | input | 8 | Operand B |
| flags_i | input | 5 | Current flags {V,H,N,Z,C}; C is the carry/borrow input |
| result_o | output | 8 | Registered result |
| flags_o | output | 5 | Registered updated flags {V,H,N,Z,C} |
| flag_we_o | output | 5 | Registered mask of flags written by the operation |
| wb_o | output | 1 | Registered result write-back strobe |

## Verification
The operations are first driven with hand-picked boundary operands: 0x7F+1 and 0xFF+1 for signed overflow against carry, 0x0F+1 for half-carry, 0-1 and 0x80-1 for borrow against overflow, 0x80 and 0 for negate, and 0x7F/0x80 for increment and decrement. The incoming flag vector is varied so that kept H and C and the carry-in of the rotates and carry operations are visible. A long stream of random opcodes, operands and flag vectors, including undefined opcodes, then separates errors in the write mask and flag pass-through from errors in the result datapath. Every cycle is compared with a behavioural reference computed in integer arithmetic.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int OP_W = 5;
  localparam int NF   = 5;

  // flag vector bit positions
  localparam int FV = 4;
  localparam int FH = 3;
  localparam int FN = 2;
  localparam int FZ = 1;
  localparam int FC = 0;

  localparam logic [NF-1:0] MASK_ALL  = 5'b11111;
  localparam logic [NF-1:0] MASK_VNZC = 5'b10111;
  localparam logic [NF-1:0] MASK_VNZ  = 5'b10110;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,
    OP_AND  = 5'd5,
    OP_ORA  = 5'd6,
    OP_EOR  = 5'd7,
    OP_BIT  = 5'd8,
    OP_PASS = 5'd9,
    OP_ASR  = 5'd10,
    OP_LSR  = 5'd11,
    OP_LSL  = 5'd12,
    OP_ROL  = 5'd13,
    OP_ROR  = 5'd14,
    OP_INC  = 5'd15,
    OP_DEC  = 5'd16,
    OP_NEG  = 5'd17,
    OP_COM  = 5'd18,
    OP_CLR  = 5'd19
  } alu_op_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic            cin,
  output logic            hit,
  output logic [W-1:0]    res,
  output logic [NF-1:0]   flg,
  output logic [NF-1:0]   we,
  output logic            wb
);

  localparam int HB = W / 2;
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] SIGN_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] SIGN_MAX = {1'b0, {(W-1){1'b1}}};

  logic         sub_mode;
  logic         use_cin;
  logic [W:0]   ax, bx, cx, sum, th, tv;
  logic [W-1:0] inc_r, dec_r, neg_r;

  always_comb begin
    sub_mode = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
    use_cin  = (op == OP_ADC) || (op == OP_SBC);
  end

  assign ax  = {1'b0, a};
  assign bx  = {1'b0, b};
  assign cx  = {{W{1'b0}}, use_cin & cin};
  assign sum = sub_mode ? (ax - bx - cx) : (ax + bx + cx);
  assign th  = ax ^ bx ^ sum;
  assign tv  = th ^ (sum >> 1);

  assign inc_r = a + ONE;
  assign dec_r = a - ONE;
  assign neg_r = {W{1'b0}} - a;

  always_comb begin
    hit = 1'b1;
    res = '0;
    flg = '0;
    we  = '0;
    wb  = 1'b1;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
        res     = sum[W-1:0];
        flg[FV] = tv[W-1];
        flg[FC] = sum[W];
        flg[FH] = th[HB];
        we      = sub_mode ? MASK_VNZC : MASK_ALL;
        wb      = (op != OP_CMP);
      end
      OP_INC: begin
        res     = inc_r;
        flg[FV] = (inc_r == SIGN_MIN);
        we      = MASK_VNZ;
      end
      OP_DEC: begin
        res     = dec_r;
        flg[FV] = (dec_r == SIGN_MAX);
        we      = MASK_VNZ;
      end
      OP_NEG: begin
        res     = neg_r;
        flg[FV] = (a == SIGN_MIN);
        flg[FC] = (a != '0);
        we      = MASK_VNZC;
      end
      default: begin
        hit = 1'b0;
        wb  = 1'b0;
      end
    endcase
    flg[FN] = res[W-1];
    flg[FZ] = (res == '0);
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic            hit,
  output logic [W-1:0]    res,
  output logic [NF-1:0]   flg,
  output logic [NF-1:0]   we,
  output logic            wb
);

  always_comb begin
    hit = 1'b1;
    res = '0;
    flg = '0;
    we  = MASK_VNZ;
    wb  = 1'b1;
    case (op)
      OP_AND:  res = a & b;
      OP_ORA:  res = a | b;
      OP_EOR:  res = a ^ b;
      OP_BIT: begin
        res = a & b;
        wb  = 1'b0;
      end
      OP_PASS: res = b;
      OP_COM: begin
        res     = ~a;
        flg[FC] = 1'b1;
        we      = MASK_VNZC;
      end
      OP_CLR:  res = '0;
      default: begin
        hit = 1'b0;
        we  = '0;
        wb  = 1'b0;
      end
    endcase
    flg[FN] = res[W-1];
    flg[FZ] = (res == '0);
    if (op == OP_CLR) begin
      flg[FN] = 1'b0;
      flg[FZ] = 1'b1;
    end
  end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic            cin,
  output logic            hit,
  output logic [W-1:0]    res,
  output logic [NF-1:0]   flg,
  output logic [NF-1:0]   we,
  output logic            wb
);

  logic right_dir;
  logic fill_bit;
  logic out_bit;

  always_comb begin
    right_dir = (op == OP_ASR) || (op == OP_LSR) || (op == OP_ROR);
    case (op)
      OP_ASR:  fill_bit = a[W-1];
      OP_ROL,
      OP_ROR:  fill_bit = cin;
      default: fill_bit = 1'b0;
    endcase
    out_bit = right_dir ? a[0] : a[W-1];
  end

  always_comb begin
    hit = 1'b1;
    wb  = 1'b1;
    we  = MASK_VNZC;
    flg = '0;
    case (op)
      OP_ASR, OP_LSR, OP_LSL, OP_ROL, OP_ROR: ;
      default: begin
        hit = 1'b0;
        wb  = 1'b0;
        we  = '0;
      end
    endcase
    res     = right_dir ? {fill_bit, a[W-1:1]} : {a[W-2:0], fill_bit};
    flg[FC] = out_bit;
    flg[FN] = res[W-1];
    flg[FZ] = (res == '0);
    flg[FV] = out_bit ^ res[W-1];
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [NF-1:0]   flags_i,
  output logic [W-1:0]    result_o,
  output logic [NF-1:0]   flags_o,
  output logic [NF-1:0]   flag_we_o,
  output logic            wb_o
);

  logic            as_hit, lg_hit, sh_hit;
  logic [W-1:0]    as_res, lg_res, sh_res;
  logic [NF-1:0]   as_flg, lg_flg, sh_flg;
  logic [NF-1:0]   as_we,  lg_we,  sh_we;
  logic            as_wb,  lg_wb,  sh_wb;

  logic [W-1:0]    sel_res;
  logic [NF-1:0]   sel_flg, sel_we, merged;
  logic            sel_wb;

  alu8_addsub #(.W(W)) i_addsub (
    .op(op_i), .a(a_i), .b(b_i), .cin(flags_i[FC]),
    .hit(as_hit), .res(as_res), .flg(as_flg), .we(as_we), .wb(as_wb)
  );

  alu8_logic #(.W(W)) i_logic (
    .op(op_i), .a(a_i), .b(b_i),
    .hit(lg_hit), .res(lg_res), .flg(lg_flg), .we(lg_we), .wb(lg_wb)
  );

  alu8_shift #(.W(W)) i_shift (
    .op(op_i), .a(a_i), .cin(flags_i[FC]),
    .hit(sh_hit), .res(sh_res), .flg(sh_flg), .we(sh_we), .wb(sh_wb)
  );

  always_comb begin
    if (as_hit) begin
      sel_res = as_res; sel_flg = as_flg; sel_we = as_we; sel_wb = as_wb;
    end else if (lg_hit) begin
      sel_res = lg_res; sel_flg = lg_flg; sel_we = lg_we; sel_wb = lg_wb;
    end else if (sh_hit) begin
      sel_res = sh_res; sel_flg = sh_flg; sel_we = sh_we; sel_wb = sh_wb;
    end else begin
      sel_res = '0;     sel_flg = '0;     sel_we = '0;    sel_wb = 1'b0;
    end
  end

  for (genvar g = 0; g < NF; g++) begin : g_merge
    assign merged[g] = sel_we[g] ? sel_flg[g] : flags_i[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      flags_o   <= '0;
      flag_we_o <= '0;
      wb_o      <= 1'b0;
    end else begin
      result_o  <= sel_res;
      flags_o   <= merged;
      flag_we_o <= sel_we;
      wb_o      <= sel_wb;
    end
  end

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    a_i,
  input logic [NF-1:0]   flags_i,
  input logic [W-1:0]    result_o,
  input logic [NF-1:0]   flags_o,
  input logic [NF-1:0]   flag_we_o,
  input logic            wb_o
);

  logic past_ok;
  logic rst_d;

  always_ff @(posedge clk) begin
    rst_d   <= rst;
    past_ok <= !rst;
  end

  // R1: the first edge after reset shows the cleared outputs
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (result_o == '0 && flags_o == '0 && flag_we_o == '0 && !wb_o));

  // R12: unwritten flags follow the previous cycle's input flags
  p_unwritten_kept_r12: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((flags_o & ~flag_we_o) == ($past(flags_i) & ~flag_we_o)));

  // R3: half-carry is written only by the additions
  p_h_only_add_r3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && flag_we_o[FH]) |-> ($past(op_i) == OP_ADD || $past(op_i) == OP_ADC));

  // R5: compare and bit-test never write back
  p_no_wb_r5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && ($past(op_i) == OP_CMP || $past(op_i) == OP_BIT)) |-> !wb_o);

  // R8: shift overflow is C xor N
  p_shift_v_r8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(op_i) >= OP_ASR && $past(op_i) <= OP_ROR)
      |-> (flags_o[FV] == (flags_o[FC] ^ flags_o[FN])));

  // R11: complement sets C, clears V, inverts A
  p_com_flags_r11: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(op_i) == OP_COM)
      |-> (flags_o[FC] && !flags_o[FV] && result_o == ~$past(a_i)));

  // R13: written Z agrees with a written-back result
  p_z_result_r13: assert property (@(posedge clk) disable iff (rst)
    (past_ok && wb_o && flag_we_o[FZ]) |-> (flags_o[FZ] == (result_o == '0)));

  // R13: written N agrees with a written-back result
  p_n_result_r13: assert property (@(posedge clk) disable iff (rst)
    (past_ok && wb_o && flag_we_o[FN]) |-> (flags_o[FN] == result_o[W-1]));

endmodule

bind alu8_core alu8_core_chk #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .flags_i(flags_i),
  .result_o(result_o), .flags_o(flags_o), .flag_we_o(flag_we_o), .wb_o(wb_o)
);

// File: tb/test_alu8_core.sv
module test_alu8_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op_i = '0;
  logic [7:0] a_i = '0;
  logic [7:0] b_i = '0;
  logic [4:0] flags_i = '0;
  logic [7:0] result_o;
  logic [4:0] flags_o;
  logic [4:0] flag_we_o;
  logic       wb_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;  // 125 MHz

  alu8_core i_alu8_core (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i), .flags_i(flags_i),
    .result_o(result_o), .flags_o(flags_o), .flag_we_o(flag_we_o), .wb_o(wb_o)
  );

  // behavioural reference, flag weights V=16 H=8 N=4 Z=2 C=1
  function automatic void ref_model(input int op, input int a, input int b, input int f,
                                    output int r, output int nf, output int we, output int wb);
    int s, v, h, n, z, c, cin, newf;
    cin = f & 1;
    v = 0; h = 0; c = 0; r = 0; we = 0; wb = 1;
    case (op)
      0, 1: begin
        s = a + b + ((op == 1) ? cin : 0);
        r = s & 255; c = (s >> 8) & 1;
        v = ((a ^ b ^ s ^ (s >> 1)) >> 7) & 1;
        h = ((a ^ b ^ s) >> 4) & 1;
        we = 31;
      end
      2, 3, 4: begin
        s = (a - b - ((op == 3) ? cin : 0)) & 511;
        r = s & 255; c = (s >> 8) & 1;
        v = ((a ^ b ^ s ^ (s >> 1)) >> 7) & 1;
        we = 23; wb = (op != 4);
      end
      5: begin r = a & b; we = 22; end
      6: begin r = a | b; we = 22; end
      7: begin r = a ^ b; we = 22; end
      8: begin r = a & b; we = 22; wb = 0; end
      9: begin r = b;     we = 22; end
      10: begin c = a & 1;  r = (a >> 1) | (a & 128); we = 23; end
      11: begin c = a & 1;  r = a >> 1; we = 23; end
      12: begin c = a >> 7; r = (a * 2) & 255; we = 23; end
      13: begin c = a >> 7; r = ((a * 2) + cin) & 255; we = 23; end
      14: begin c = a & 1;  r = (a >> 1) + cin * 128; we = 23; end
      15: begin r = (a + 1) & 255; v = (r == 128); we = 22; end
      16: begin r = (a + 255) & 255; v = (r == 127); we = 22; end
      17: begin r = (256 - a) & 255; v = (a == 128); c = (a != 0); we = 23; end
      18: begin r = 255 - a; c = 1; we = 23; end
      19: begin r = 0; we = 22; end
      default: begin r = 0; we = 0; wb = 0; end
    endcase
    n = (r >> 7) & 1;
    z = (r == 0);
    if (op >= 10 && op <= 14) v = c ^ n;
    newf = v * 16 + h * 8 + n * 4 + z * 2 + c;
    nf = (newf & we) | (f & ~we & 31);
  endfunction

  function automatic string req_of(input int op);
    case (op)
      0, 1:          return "R3";
      2, 3:          return "R4";
      4, 8:          return "R5";
      5, 6, 7, 9:    return "R6";
      10, 11, 12, 13, 14: return "R7";
      15, 16:        return "R9";
      17:            return "R10";
      18, 19:        return "R11";
      default:       return "R12";
    endcase
  endfunction

  task automatic apply(input int op, input int a, input int b, input int f);
    int er, ef, ewe, ewb;
    string tag, ftag;
    @(negedge clk);
    op_i = op[4:0]; a_i = a[7:0]; b_i = b[7:0]; flags_i = f[4:0];
    ref_model(op, a, b, f, er, ef, ewe, ewb);
    tag  = req_of(op);
    ftag = (op >= 10 && op <= 14) ? "R8" : tag;
    @(negedge clk);
    n_tests++;
    if (result_o !== er[7:0] || wb_o !== ewb[0]) begin
      n_fail++;
      $display("FAIL %s/R2 op=%0d a=%h b=%h: result=%h wb=%b expected result=%h wb=%b",
               tag, op, a, b, result_o, wb_o, er[7:0], ewb[0]);
    end
    n_tests++;
    if (flags_o !== ef[4:0] || flag_we_o !== ewe[4:0]) begin
      n_fail++;
      $display("FAIL %s/R12/R13 op=%0d a=%h f=%b: flags=%b we=%b expected flags=%b we=%b",
               ftag, op, a, f, flags_o, flag_we_o, ef[4:0], ewe[4:0]);
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    // R1: reset with active inputs
    op_i = 5'd0; a_i = 8'hFF; b_i = 8'h01; flags_i = 5'b11111;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (result_o !== 8'h00 || flags_o !== 5'b0 || flag_we_o !== 5'b0 || wb_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: result=%h flags=%b we=%b wb=%b expected all zero",
               result_o, flags_o, flag_we_o, wb_o);
    end
    rst = 1'b0;

    // R3: overflow, carry, half-carry, carry-in
    apply(0, 8'h7F, 8'h01, 0);
    apply(0, 8'hFF, 8'h01, 0);
    apply(0, 8'h0F, 8'h01, 0);
    apply(1, 8'h10, 8'h20, 1);
    apply(1, 8'hFF, 8'h00, 1);
    // R4: borrow, overflow, H kept set
    apply(2, 8'h00, 8'h01, 8);
    apply(2, 8'h80, 8'h01, 0);
    apply(3, 8'h05, 8'h05, 9);
    apply(3, 8'h05, 8'h05, 0);
    // R5: compare and bit-test do not write back
    apply(4, 8'h42, 8'h42, 31);
    apply(8, 8'hF0, 8'h0F, 9);
    // R6: logic ops keep H and C
    apply(5, 8'hC3, 8'hF0, 25);
    apply(6, 8'h00, 8'h00, 16);
    apply(7, 8'hAA, 8'h55, 1);
    apply(9, 8'h00, 8'h80, 24);
    // R7/R8: shifts and rotates
    apply(10, 8'h81, 0, 0);
    apply(11, 8'h01, 0, 8);
    apply(12, 8'h80, 0, 0);
    apply(12, 8'h40, 0, 0);
    apply(13, 8'h7F, 0, 1);
    apply(14, 8'h02, 0, 1);
    apply(14, 8'h01, 0, 0);
    // R9: increment/decrement overflow points, C kept
    apply(15, 8'h7F, 0, 1);
    apply(15, 8'hFF, 0, 0);
    apply(16, 8'h80, 0, 9);
    apply(16, 8'h00, 0, 0);
    // R10: negate corners
    apply(17, 8'h80, 0, 0);
    apply(17, 8'h00, 0, 31);
    apply(17, 8'h01, 0, 8);
    // R11: complement and clear
    apply(18, 8'hFF, 0, 16);
    apply(18, 8'h0F, 0, 0);
    apply(19, 8'h5A, 0, 29);
    // R12: undefined opcodes change nothing
    apply(20, 8'h12, 8'h34, 21);
    apply(31, 8'hFF, 8'hFF, 10);

    // mixed random stream
    for (int i = 0; i < 800; i++)
      apply($urandom % 32, $urandom % 256, $urandom % 256, $urandom % 32);

    done = 1;
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_up();
    end
  end

endmodule